// File: doc/BRIEF.md
# Interrupt pin trigger controller

This block holds the per-input state of an interrupt router: for each of a parameterised number of input pins it keeps a pending bit, a mask bit, a trigger-mode bit (edge or level) and an in-service flag for level-mode pins. Devices report level changes one at a time as an event with a pin index and a level. End-of-interrupt notices arrive with a pin index. A configuration write port updates the mask and the trigger mode of one pin.

Whenever a pin earns service, the block marks it as needing service. A lowest-index picker then hands the pins to a downstream dispatcher one per cycle. The dispatcher sees a single-cycle deliver request with the pin index and its trigger mode, and it answers with an accept flag in the same cycle. A masked pin that reaches the picker is consumed silently. A raise that does not lead to service is reported as a merged (coalesced) request, and every end-of-interrupt is echoed as a one-cycle acknowledge notice.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: After reset every pin is masked and edge-mode, with pending, in-service and need-service state clear, so `dlv_req`, `coal_valid` and `ack_valid` stay low until stimulus arrives.
- R2: An event with level 0 clears the pin's pending bit in the same edge, in either trigger mode; a later end-of-interrupt or configuration write for that pin then causes no delivery.
- R3: An edge-mode pin (trigger bit 0) is marked for service only by a level-1 event that moves its pending bit from 0 to 1; a level-1 event while it is already pending gives no delivery.
- R4: A level-mode pin (trigger bit 1) is marked for service by a level-1 event only while its in-service flag is clear.
- R5: A level-1 event that does not mark its pin for service raises `coal_valid` for exactly the next cycle, with `coal_pin` equal to the event's pin.
- R6: A pin picked while masked produces no `dlv_req`, and its need-service mark is consumed.
- R7: When `dlv_req` is high for a level-mode pin and `dlv_accept` is high in that cycle, the pin's in-service flag is set; without accept it stays clear.
- R8: A level-mode end-of-interrupt clears the in-service flag; if the pin is unmasked and pending, it is marked for service again.
- R9: An end-of-interrupt for an edge-mode pin changes no pin state.
- R10: Each end-of-interrupt with an in-range index raises `ack_valid` for exactly the next cycle, with `ack_pin` equal to that index.
- R11: At most one pin is delivered per cycle, always the lowest-indexed pin marked for service, one cycle after it was marked; the others keep their marks.
- R12: Events, end-of-interrupts and configuration writes whose pin index is at or above `NUM_PINS` have no effect and give no notice.
- R13: A configuration write sets the pin's mask and trigger mode and clears its in-service flag; if the written mode is level and the pin is pending, the pin is marked for service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A device level change is presented |
| evt_pin | input | PIN_W | Pin index of the level change |
| evt_level | input | 1 | New level of that pin |
| eoi_valid | input | 1 | End-of-interrupt notice is presented |
| eoi_pin | input | PIN_W | Pin index matched to the acknowledged vector |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_pin | input | PIN_W | Pin index of the configuration write |
| cfg_mask | input | 1 | New mask bit (1 = masked) |
| cfg_level | input | 1 | New trigger mode (1 = level, 0 = edge) |
| dlv_accept | input | 1 | Dispatcher accepted the current delivery |
| dlv_req | output | 1 | Single-cycle deliver request |
| dlv_pin | output | PIN_W | Pin being delivered |
| dlv_level | output | 1 | Trigger mode of the pin being delivered |
| coal_valid | output | 1 | A raise was merged into existing state |
| coal_pin | output | PIN_W | Pin whose raise was merged |
| ack_valid | output | 1 | End-of-interrupt acknowledge notice |
| ack_pin | output | PIN_W | Pin index carried by the notice |

## Verification
Directed patterns separate the trigger modes. A repeated raise on an edge pin must merge, while a repeated raise on a level pin merges only once a delivery was accepted. Withholding accept shows that the in-service flag follows the dispatcher's answer and not the request. One cycle that combines a raise, an end-of-interrupt and a configuration write marks three pins at once, which checks the ordering of the picker. Out-of-range indices show that nothing leaks. A long random stream with random accepts is then compared against a behavioural model on every cycle to catch interactions the directed cases miss.

// File: rtl/itc_pkg.sv
package itc_pkg;

   // Implementation choice for the lowest-index picker.
   typedef enum logic {
      PICK_SCAN = 1'b0,   // priority loop, index first then one-hot
      PICK_TWOS = 1'b1    // isolate lowest set bit, then encode
   } pick_style_e;

   // True when a pin index addresses an existing pin.
   function automatic logic pin_in_range(input int unsigned pin, input int unsigned npins);
      return pin < npins;
   endfunction

endpackage

// File: rtl/itc_pin_cell.sv
module itc_pin_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_hit,
   input  logic evt_level,
   input  logic eoi_hit,
   input  logic cfg_hit,
   input  logic cfg_mask,
   input  logic cfg_level,
   input  logic grant,
   input  logic accept,
   output logic need_o,
   output logic mask_o,
   output logic lvl_o,
   output logic rack_o,
   output logic coal_o
);

   logic pend_q, mask_q, lvl_q, rack_q, need_q;
   logic raise, svc_evt, svc_eoi, svc_cfg;
   logic rack_set, rack_clr;

   always_comb begin
      raise    = evt_hit & evt_level;
      // Edge pins need a fresh 0->1 pending change; level pins need the
      // in-service flag clear.
      svc_evt  = raise & (lvl_q ? ~rack_q : ~pend_q);
      svc_eoi  = eoi_hit & lvl_q & ~mask_q & pend_q;
      svc_cfg  = cfg_hit & cfg_level & pend_q;
      rack_clr = (eoi_hit & lvl_q) | cfg_hit;
      rack_set = grant & ~mask_q & lvl_q & accept;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         mask_q <= 1'b1;
         lvl_q  <= 1'b0;
         rack_q <= 1'b0;
         need_q <= 1'b0;
      end else begin
         if (evt_hit) pend_q <= evt_level;
         if (cfg_hit) begin
            mask_q <= cfg_mask;
            lvl_q  <= cfg_level;
         end
         rack_q <= (rack_q & ~rack_clr) | rack_set;
         need_q <= (need_q & ~grant) | svc_evt | svc_eoi | svc_cfg;
      end
   end

   assign need_o = need_q;
   assign mask_o = mask_q;
   assign lvl_o  = lvl_q;
   assign rack_o = rack_q;
   assign coal_o = raise & ~svc_evt;

endmodule

// File: rtl/itc_lowest_pick.sv
module itc_lowest_pick #(
   parameter int                  N     = 24,
   parameter int                  W     = 5,
   parameter itc_pkg::pick_style_e STYLE = itc_pkg::PICK_SCAN
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx,
   output logic [N-1:0] grant
);

   assign any = |req;

   generate
      if (STYLE == itc_pkg::PICK_TWOS) begin : g_twos
         always_comb begin
            grant = req & (~req + N'(1));
            idx   = '0;
            for (int i = 0; i < N; i++) begin
               if (grant[i]) idx = idx | W'(i);
            end
         end
      end else begin : g_scan
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) idx = W'(i);
            end
            grant = any ? (N'(1) << idx) : '0;
         end
      end
   endgenerate

endmodule

// File: rtl/irq_trigger_ctrl.sv
module irq_trigger_ctrl #(
   parameter int                   NUM_PINS = 24,
   parameter int                   PIN_W    = 5,
   parameter itc_pkg::pick_style_e PICK     = itc_pkg::PICK_SCAN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_valid,
   input  logic [PIN_W-1:0] evt_pin,
   input  logic             evt_level,
   input  logic             eoi_valid,
   input  logic [PIN_W-1:0] eoi_pin,
   input  logic             cfg_wr,
   input  logic [PIN_W-1:0] cfg_pin,
   input  logic             cfg_mask,
   input  logic             cfg_level,
   input  logic             dlv_accept,
   output logic             dlv_req,
   output logic [PIN_W-1:0] dlv_pin,
   output logic             dlv_level,
   output logic             coal_valid,
   output logic [PIN_W-1:0] coal_pin,
   output logic             ack_valid,
   output logic [PIN_W-1:0] ack_pin
);

   localparam int N = NUM_PINS;

   generate
      if (NUM_PINS < 2 || NUM_PINS > (1 << PIN_W)) begin : g_bad_pins
         $error("irq_trigger_ctrl: NUM_PINS must be 2..2**PIN_W");
      end
   endgenerate

   logic [N-1:0] evt_hit, eoi_hit, cfg_hit;
   logic [N-1:0] need_vec, mask_vec, lvl_vec, rack_vec, coal_vec, grant_vec;
   logic         pick_any;
   logic [PIN_W-1:0] pick_idx;
   logic         eoi_in;

   // Index decode and per-pin state.
   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_pin
         assign evt_hit[gi] = evt_valid & (evt_pin == PIN_W'(gi));
         assign eoi_hit[gi] = eoi_valid & (eoi_pin == PIN_W'(gi));
         assign cfg_hit[gi] = cfg_wr    & (cfg_pin == PIN_W'(gi));

         itc_pin_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_hit   (evt_hit[gi]),
            .evt_level (evt_level),
            .eoi_hit   (eoi_hit[gi]),
            .cfg_hit   (cfg_hit[gi]),
            .cfg_mask  (cfg_mask),
            .cfg_level (cfg_level),
            .grant     (grant_vec[gi]),
            .accept    (dlv_accept),
            .need_o    (need_vec[gi]),
            .mask_o    (mask_vec[gi]),
            .lvl_o     (lvl_vec[gi]),
            .rack_o    (rack_vec[gi]),
            .coal_o    (coal_vec[gi])
         );
      end
   endgenerate

   itc_lowest_pick #(.N(N), .W(PIN_W), .STYLE(PICK)) u_pick (
      .req   (need_vec),
      .any   (pick_any),
      .idx   (pick_idx),
      .grant (grant_vec)
   );

   assign dlv_req   = pick_any & ~mask_vec[pick_idx];
   assign dlv_pin   = pick_idx;
   assign dlv_level = lvl_vec[pick_idx];

   assign eoi_in = itc_pkg::pin_in_range(32'(eoi_pin), N) & eoi_valid;

   // Notices: merged raise and end-of-interrupt echo, one cycle later.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         coal_valid <= 1'b0;
         coal_pin   <= '0;
         ack_valid  <= 1'b0;
         ack_pin    <= '0;
      end else begin
         coal_valid <= |coal_vec;
         coal_pin   <= evt_pin;
         ack_valid  <= eoi_in;
         ack_pin    <= eoi_pin;
      end
   end

endmodule

// File: rtl/itc_checker.sv
module itc_checker #(
   parameter int NUM_PINS = 24,
   parameter int PIN_W    = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                evt_valid,
   input logic [PIN_W-1:0]    evt_pin,
   input logic                evt_level,
   input logic                eoi_valid,
   input logic [PIN_W-1:0]    eoi_pin,
   input logic                dlv_accept,
   input logic                dlv_req,
   input logic [PIN_W-1:0]    dlv_pin,
   input logic                dlv_level,
   input logic                coal_valid,
   input logic [PIN_W-1:0]    coal_pin,
   input logic                ack_valid,
   input logic [PIN_W-1:0]    ack_pin,
   input logic [NUM_PINS-1:0] need_vec,
   input logic [NUM_PINS-1:0] lvl_vec,
   input logic [NUM_PINS-1:0] rack_vec
);

   logic               eoi_in, evt_in;
   logic [NUM_PINS-1:0] below;

   assign eoi_in = eoi_valid && ({1'b0, eoi_pin} < (PIN_W+1)'(NUM_PINS));
   assign evt_in = evt_valid && ({1'b0, evt_pin} < (PIN_W+1)'(NUM_PINS));
   assign below  = (NUM_PINS'(1) << dlv_pin) - NUM_PINS'(1);

   a_r10_ack_follows_eoi: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_in |=> (ack_valid && ack_pin == $past(eoi_pin)));

   a_r12_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !eoi_in |=> !ack_valid);

   a_r5_merge_needs_raise: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_in && evt_level) |=> !coal_valid);

   a_r5_merge_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_in && evt_level) |=> (!coal_valid || coal_pin == $past(evt_pin)));

   a_r11_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_req |-> ((need_vec & below) == '0));

   a_r11_pin_range: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_req |-> ({1'b0, dlv_pin} < (PIN_W+1)'(NUM_PINS)));

   a_r7_flag_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_req && dlv_accept && dlv_level) |=> rack_vec[$past(dlv_pin)]);

   a_r4_flag_blocks_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_in && evt_level && lvl_vec[evt_pin] && rack_vec[evt_pin]) |=> coal_valid);

endmodule

bind irq_trigger_ctrl itc_checker #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_itc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_valid  (evt_valid),
   .evt_pin    (evt_pin),
   .evt_level  (evt_level),
   .eoi_valid  (eoi_valid),
   .eoi_pin    (eoi_pin),
   .dlv_accept (dlv_accept),
   .dlv_req    (dlv_req),
   .dlv_pin    (dlv_pin),
   .dlv_level  (dlv_level),
   .coal_valid (coal_valid),
   .coal_pin   (coal_pin),
   .ack_valid  (ack_valid),
   .ack_pin    (ack_pin),
   .need_vec   (need_vec),
   .lvl_vec    (lvl_vec),
   .rack_vec   (rack_vec)
);

// File: tb/irq_trigger_ctrl_bench.sv
`timescale 1ns/1ps
module irq_trigger_ctrl_bench;

   localparam int N = 24;
   localparam int W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic evt_valid = 0, evt_level = 0, eoi_valid = 0, cfg_wr = 0;
   logic cfg_mask = 0, cfg_level = 0, dlv_accept = 1;
   logic [W-1:0] evt_pin = '0, eoi_pin = '0, cfg_pin = '0;
   logic dlv_req, dlv_level, coal_valid, ack_valid;
   logic [W-1:0] dlv_pin, coal_pin, ack_pin;

   always #2 clk = ~clk;

   irq_trigger_ctrl #(.NUM_PINS(N), .PIN_W(W)) u_irq_trigger_ctrl (
      .clk(clk), .rst_n(rst_n),
      .evt_valid(evt_valid), .evt_pin(evt_pin), .evt_level(evt_level),
      .eoi_valid(eoi_valid), .eoi_pin(eoi_pin),
      .cfg_wr(cfg_wr), .cfg_pin(cfg_pin), .cfg_mask(cfg_mask), .cfg_level(cfg_level),
      .dlv_accept(dlv_accept),
      .dlv_req(dlv_req), .dlv_pin(dlv_pin), .dlv_level(dlv_level),
      .coal_valid(coal_valid), .coal_pin(coal_pin),
      .ack_valid(ack_valid), .ack_pin(ack_pin)
   );

   // Behavioural reference state
   bit [N-1:0] m_pend, m_mask, m_lvl, m_rack, m_need;
   bit m_coal, m_ack;
   int m_coalp, m_ackp;

   int n_cmp = 0, n_bad = 0, cycles = 0;
   bit done = 0;
   string cur_req = "R1";
   int ph_dlv, ph_coal, ph_ack, last_coalp, last_ackp;
   int ph_pin[8];

   task automatic report(input bit ok, input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_pend = '0; m_mask = '1; m_lvl = '0; m_rack = '0; m_need = '0;
      m_coal = 0; m_ack = 0; m_coalp = 0; m_ackp = 0;
   endtask

   task automatic step();
      int g, p;
      bit e_req, e_lvl, bad, nc;
      bit [N-1:0] n_pend, n_mask, n_lvl, n_rack, n_need;
      #1;
      g = -1;
      for (int i = N - 1; i >= 0; i--) if (m_need[i]) g = i;
      e_req = (g >= 0) && !m_mask[g];
      e_lvl = e_req ? m_lvl[g] : 1'b0;
      bad = (dlv_req !== e_req) || (coal_valid !== m_coal) || (ack_valid !== m_ack);
      if (e_req && (int'(dlv_pin) != g || dlv_level != e_lvl)) bad = 1;
      if (m_coal && int'(coal_pin) != m_coalp) bad = 1;
      if (m_ack && int'(ack_pin) != m_ackp) bad = 1;
      n_cmp++;
      if (bad) begin
         n_bad++;
         $display("FAIL %s cycle %0d actual req/pin/lvl/coal/cpin/ack/apin=%0b/%0d/%0b/%0b/%0d/%0b/%0d expected=%0b/%0d/%0b/%0b/%0d/%0b/%0d",
                  cur_req, cycles, dlv_req, dlv_pin, dlv_level, coal_valid, coal_pin, ack_valid, ack_pin,
                  e_req, (e_req ? g : 0), e_lvl, m_coal, m_coalp, m_ack, m_ackp);
      end
      if (dlv_req === 1'b1) begin
         if (ph_dlv < 8) ph_pin[ph_dlv] = int'(dlv_pin);
         ph_dlv++;
      end
      if (coal_valid === 1'b1) begin ph_coal++; last_coalp = int'(coal_pin); end
      if (ack_valid === 1'b1) begin ph_ack++; last_ackp = int'(ack_pin); end
      // next reference state from current state and inputs
      n_pend = m_pend; n_mask = m_mask; n_lvl = m_lvl; n_rack = m_rack; n_need = m_need;
      if (g >= 0) n_need[g] = 0;
      nc = 0;
      if (evt_valid && int'(evt_pin) < N) begin
         p = int'(evt_pin);
         if (evt_level) begin
            if (m_lvl[p] ? !m_rack[p] : !m_pend[p]) n_need[p] = 1;
            else nc = 1;
            n_pend[p] = 1;
         end else n_pend[p] = 0;
      end
      if (eoi_valid && int'(eoi_pin) < N) begin
         p = int'(eoi_pin);
         if (m_lvl[p]) begin
            n_rack[p] = 0;
            if (!m_mask[p] && m_pend[p]) n_need[p] = 1;
         end
      end
      if (cfg_wr && int'(cfg_pin) < N) begin
         p = int'(cfg_pin);
         n_mask[p] = cfg_mask; n_lvl[p] = cfg_level; n_rack[p] = 0;
         if (cfg_level && m_pend[p]) n_need[p] = 1;
      end
      if (e_req && dlv_accept && m_lvl[g]) n_rack[g] = 1;
      m_pend = n_pend; m_mask = n_mask; m_lvl = n_lvl; m_rack = n_rack; m_need = n_need;
      m_coal = nc; m_coalp = int'(evt_pin);
      m_ack = eoi_valid && int'(eoi_pin) < N; m_ackp = int'(eoi_pin);
      @(posedge clk);
      @(negedge clk);
      evt_valid = 0; eoi_valid = 0; cfg_wr = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic phase(input string tag);
      cur_req = tag; ph_dlv = 0; ph_coal = 0; ph_ack = 0;
      for (int i = 0; i < 8; i++) ph_pin[i] = -1;
   endtask

   task automatic do_evt(input int p, input bit l);
      evt_valid = 1; evt_pin = W'(p); evt_level = l; step(); idle(4);
   endtask
   task automatic do_eoi(input int p);
      eoi_valid = 1; eoi_pin = W'(p); step(); idle(4);
   endtask
   task automatic do_cfg(input int p, input bit m, input bit l);
      cfg_wr = 1; cfg_pin = W'(p); cfg_mask = m; cfg_level = l; step(); idle(4);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: quiet after reset
      phase("R1");
      idle(4);
      report(ph_dlv == 0 && ph_coal == 0 && ph_ack == 0, "R1", "notices after reset", ph_dlv + ph_coal + ph_ack, 0);
      // R6: raise on a masked pin (reset state) delivers nothing
      phase("R6");
      do_evt(3, 1);
      report(ph_dlv == 0, "R6", "deliveries from masked pin", ph_dlv, 0);
      do_evt(3, 0);
      // R13: configure; a pending pin written to level mode is serviced
      phase("R13");
      do_cfg(3, 0, 0); do_cfg(5, 0, 1); do_cfg(7, 0, 1); do_cfg(12, 0, 0);
      do_evt(9, 1);
      report(ph_dlv == 0, "R13", "deliveries before unmasking pin 9", ph_dlv, 0);
      do_cfg(9, 0, 1);
      report(ph_dlv == 1 && ph_pin[0] == 9, "R13", "delivery after level write of pending pin", ph_pin[0], 9);
      do_evt(9, 0);
      // R3: edge pin
      phase("R3");
      do_evt(3, 1); do_evt(3, 1); do_evt(3, 0); do_evt(3, 1);
      report(ph_dlv == 2, "R3", "edge deliveries", ph_dlv, 2);
      report(ph_coal == 1, "R3", "edge merges", ph_coal, 1);
      report(last_coalp == 3, "R5", "merged pin index", last_coalp, 3);
      // R4: level pin blocked while in service
      phase("R4");
      do_evt(5, 1); do_evt(5, 1);
      report(ph_dlv == 1 && ph_coal == 1, "R4", "level deliveries+merges", ph_dlv * 10 + ph_coal, 11);
      // R8: level end-of-interrupt re-services pending pin
      phase("R8");
      do_eoi(5);
      report(ph_dlv == 1 && ph_pin[0] == 5, "R8", "re-delivery after eoi", ph_dlv, 1);
      // R2: low level clears pending; eoi then gives nothing
      phase("R2");
      do_evt(5, 0); do_eoi(5);
      report(ph_dlv == 0, "R2", "deliveries after low level", ph_dlv, 0);
      // R7: without accept the flag stays clear
      phase("R7");
      dlv_accept = 0;
      do_evt(7, 1); do_evt(7, 1);
      dlv_accept = 1;
      report(ph_dlv == 2 && ph_coal == 0, "R7", "deliveries without accept", ph_dlv, 2);
      // R9 / R10: edge eoi changes nothing, but is acknowledged
      phase("R9");
      do_eoi(3);
      report(ph_dlv == 0, "R9", "deliveries after edge eoi", ph_dlv, 0);
      report(ph_ack == 1 && last_ackp == 3, "R10", "ack pin", last_ackp, 3);
      do_evt(3, 1);
      report(ph_coal == 1, "R9", "merge after edge eoi", ph_coal, 1);
      // R11: three pins marked in one cycle
      phase("R11");
      do_evt(5, 1);
      phase("R11");
      evt_valid = 1; evt_pin = W'(12); evt_level = 1;
      eoi_valid = 1; eoi_pin = W'(7);
      cfg_wr = 1; cfg_pin = W'(5); cfg_mask = 0; cfg_level = 1;
      step(); idle(5);
      report(ph_dlv == 3, "R11", "deliveries from joint cycle", ph_dlv, 3);
      report(ph_pin[0] == 5 && ph_pin[1] == 7 && ph_pin[2] == 12, "R11", "order first/second/third",
             ph_pin[0] * 10000 + ph_pin[1] * 100 + ph_pin[2], 50712);
      // R12: out-of-range indices
      phase("R12");
      evt_valid = 1; evt_pin = W'(30); evt_level = 1;
      eoi_valid = 1; eoi_pin = W'(28);
      cfg_wr = 1; cfg_pin = W'(25); cfg_mask = 0; cfg_level = 1;
      step(); idle(4);
      report(ph_dlv + ph_coal + ph_ack == 0, "R12", "effects of out-of-range", ph_dlv + ph_coal + ph_ack, 0);
      // Random stream against the reference model (R3 R4 R7 R8 R11)
      phase("R11-random");
      for (int k = 0; k < 3000; k++) begin
         dlv_accept = ($urandom_range(0, 3) != 0);
         if ($urandom_range(0, 1) == 1) begin
            evt_valid = 1; evt_pin = W'($urandom_range(0, 31)); evt_level = W'($urandom_range(0, 2)) != 0;
         end
         if ($urandom_range(0, 5) == 0) begin
            eoi_valid = 1; eoi_pin = W'($urandom_range(0, 27));
         end
         if ($urandom_range(0, 11) == 0) begin
            cfg_wr = 1; cfg_pin = W'($urandom_range(0, 26));
            cfg_mask = ($urandom_range(0, 3) == 0); cfg_level = ($urandom_range(0, 1) == 1);
         end
         step();
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule